// File: doc/BRIEF.md
# Addressed Bus-Node Packet Handler

This block is the protocol layer of a node on a shared multi-drop serial bus. A byte decoder in front of it delivers payload bytes and a delimiter strobe for each packet. The handler sorts every finished packet by its length only, and keeps a three-state address machine in step with the traffic. A 4-byte packet that carries the node's 32-bit identifier arms the node. The next two packets of exactly one half-framebuffer each (64 bytes, 32 words of 16 bits) are then copied out through a framebuffer write port. A frame-ready pulse follows the second half.

A one-byte packet holding 0x00 is a discovery request. The node raises a reply request only while a discovery window is open. The window is a counter that runs from reset and stays shut once it expires. The node's identifier and device type sit on constant outputs for the reply formatter. Packets of any other length, and halves that arrive while the node is not addressed, advance a saturating invalid-packet counter.

Top module: `pkt_addr_node`

## Requirements
- R1: After reset the outputs are idle (`fb_we`, `frame_ready`, `reply_req` low, `bad_count` zero). The address machine starts in the ignoring state, so a 64-byte packet that arrives before any address packet causes no writes and increments `bad_count`.
- R2: A synchronized one-byte packet of value 0x00 that ends while the discovery window is open raises `reply_req` for exactly one cycle, in the cycle after the delimiter is sampled. `reply_id` and `reply_type` carry the `NODE_ID` and `NODE_TYPE` parameters. Discovery leaves the address machine unchanged.
- R3: A discovery packet that ends after `WIN_CYCLES` cycles from reset release produces no reply request and is not counted as invalid. The window never reopens before the next reset.
- R4: A one-byte packet with a nonzero value is a command and puts the address machine into the ignoring state.
- R5: A 4-byte packet is an address, read little-endian (first byte is bits 7:0). If it equals `NODE_ID` the machine becomes addressed. Any other value makes it ignoring.
- R6: A 64-byte packet in the addressed state is the first half. Word k, formed from byte 2k (bits 7:0) and byte 2k+1 (bits 15:8), is written to `fb_addr` k in the (k+1)-th cycle after the delimiter edge, one word per cycle. The machine then expects the second half.
- R7: A 64-byte packet in the second-half state is written to `fb_addr` 32+k with the same timing. `frame_ready` pulses for one cycle in the cycle after the last word. The machine then returns to ignoring.
- R8: A synchronized packet of length 0, 2, 3, or 5 to 63, or a 64-byte packet in the ignoring state, increments `bad_count` one cycle after the delimiter and leaves the machine ignoring.
- R9: Payload bytes past the 64th are dropped, and such a packet counts as invalid (R8). No framebuffer write results from it.
- R10: A delimiter seen while `in_synced` is low produces no packet. State, `bad_count` and `reply_req` are unaffected. The byte count still restarts, so the next packet is measured from its own first byte.
- R11: `bad_count` saturates at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte or delimiter strobe from the decoder |
| in_byte | input | 8 | Decoded payload byte |
| in_eop | input | 1 | With `in_valid`: end-of-packet delimiter (no payload byte) |
| in_synced | input | 1 | Decoder has left its wait-for-sync state |
| fb_we | output | 1 | Framebuffer word write strobe |
| fb_addr | output | 6 | Framebuffer word address (half select in MSB) |
| fb_data | output | 16 | Framebuffer word data |
| frame_ready | output | 1 | One-cycle pulse after a complete frame |
| reply_req | output | 1 | One-cycle discovery reply request |
| reply_id | output | 32 | Node identifier for the reply |
| reply_type | output | 16 | Device type for the reply |
| bad_count | output | BAD_W | Saturating invalid-packet count |

## Verification
Every result is timed from the clock edge that samples the delimiter. `reply_req` and a changed `bad_count` appear one cycle after that edge. Word k appears k+1 cycles after it, and `frame_ready` appears 33 cycles after it. The bench driver stamps each expected output with that exact cycle number before the edge occurs. A negative-edge monitor compares what it sees against these stamped entries, so an early, late, missing or extra output is reported as a mismatch.

// File: rtl/pan_pkg.sv
package pan_pkg;

  typedef enum logic [1:0] {
    ST_IGNORE    = 2'd0,
    ST_ADDRESSED = 2'd1,
    ST_SECOND    = 2'd2
  } pst_e;

  typedef enum logic [2:0] {
    PK_DISC,
    PK_CMD,
    PK_ADDR,
    PK_HALF,
    PK_BAD
  } pkind_e;

  // Packet kind from length and first byte only.
  function automatic pkind_e pk_classify(input int unsigned len,
                                         input logic [7:0] b0,
                                         input int unsigned half_bytes);
    if (len == 1) return (b0 == 8'h00) ? PK_DISC : PK_CMD;
    if (len == 4) return PK_ADDR;
    if (len == half_bytes) return PK_HALF;
    return PK_BAD;
  endfunction

  // Little-endian 32-bit assembly.
  function automatic logic [31:0] le32(input logic [7:0] b0, input logic [7:0] b1,
                                       input logic [7:0] b2, input logic [7:0] b3);
    return {b3, b2, b1, b0};
  endfunction

  function automatic pst_e next_state(input pst_e cur, input pkind_e k, input logic hit);
    case (k)
      PK_DISC: return cur;
      PK_CMD:  return ST_IGNORE;
      PK_ADDR: return hit ? ST_ADDRESSED : ST_IGNORE;
      PK_HALF: return (cur == ST_ADDRESSED) ? ST_SECOND : ST_IGNORE;
      default: return ST_IGNORE;
    endcase
  endfunction

endpackage

// File: rtl/pan_rxbuf.sv
module pan_rxbuf #(
  parameter int unsigned HALF_BYTES = 64,
  parameter int unsigned WORD_W     = 16,
  parameter int unsigned LEN_W      = 7,
  parameter int unsigned IDXW       = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_eop,
  input  logic [7:0]        in_byte,
  input  logic [IDXW-1:0]   rd_idx,
  output logic [LEN_W-1:0]  pkt_len,
  output logic [7:0]        byte0,
  output logic [31:0]       addr_word,
  output logic [WORD_W-1:0] rd_word
);
  import pan_pkg::*;

  localparam int unsigned BPW = WORD_W / 8;
  localparam int unsigned BW  = $clog2(HALF_BYTES);

  logic [7:0]       mem [HALF_BYTES];
  logic [LEN_W-1:0] len_q;

  wire byte_evt = in_valid & ~in_eop;
  wire fits     = len_q < LEN_W'(HALF_BYTES);

  // Length counter saturates one past a half, which no valid kind matches.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) len_q <= '0;
    else if (in_valid && in_eop) len_q <= '0;
    else if (byte_evt && len_q <= LEN_W'(HALF_BYTES)) len_q <= len_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (byte_evt && fits) mem[len_q[BW-1:0]] <= in_byte;
  end

  always_comb begin
    for (int b = 0; b < int'(BPW); b++)
      rd_word[8*b +: 8] = mem[BW'(int'(rd_idx) * int'(BPW) + b)];
  end

  assign pkt_len   = len_q;
  assign byte0     = mem[0];
  assign addr_word = le32(mem[0], mem[1], mem[2], mem[3]);

endmodule

// File: rtl/pan_window.sv
module pan_window #(
  parameter int unsigned WIN_CYCLES = 5_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic win_open
);
  localparam int unsigned WW = $clog2(WIN_CYCLES + 1);

  logic [WW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_q != WW'(WIN_CYCLES)) cnt_q <= cnt_q + 1'b1;
  end

  assign win_open = cnt_q < WW'(WIN_CYCLES);

endmodule

// File: rtl/pan_ctrl.sv
module pan_ctrl #(
  parameter logic [31:0]  NODE_ID    = 32'h0000_0001,
  parameter int unsigned  HALF_BYTES = 64,
  parameter int unsigned  LEN_W      = 7,
  parameter int unsigned  BAD_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eop_evt,
  input  logic [LEN_W-1:0] pkt_len,
  input  logic [7:0]       byte0,
  input  logic [31:0]      addr_word,
  input  logic             win_open,
  output logic             reply_req,
  output logic [BAD_W-1:0] bad_count,
  output logic             copy_start,
  output logic             copy_half
);
  import pan_pkg::*;

  pst_e   state_q;
  pkind_e kind;
  logic   addr_hit, ev_disc, ev_bad;

  assign kind     = pk_classify(32'(pkt_len), byte0, HALF_BYTES);
  assign addr_hit = (addr_word == NODE_ID);
  assign ev_disc  = eop_evt && kind == PK_DISC;
  assign ev_bad   = eop_evt && (kind == PK_BAD || (kind == PK_HALF && state_q == ST_IGNORE));

  assign copy_start = eop_evt && kind == PK_HALF && state_q != ST_IGNORE;
  assign copy_half  = (state_q == ST_SECOND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IGNORE;
      bad_count <= '0;
      reply_req <= 1'b0;
    end else begin
      reply_req <= ev_disc && win_open;
      if (eop_evt) state_q <= next_state(state_q, kind, addr_hit);
      if (ev_bad && bad_count != '1) bad_count <= bad_count + 1'b1;
    end
  end

endmodule

// File: rtl/pan_copy.sv
module pan_copy #(
  parameter int unsigned WORDS = 32,
  parameter int unsigned IDXW  = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            half_in,
  output logic            active,
  output logic [IDXW-1:0] idx,
  output logic            half_q,
  output logic            frame_ready
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active      <= 1'b0;
      idx         <= '0;
      half_q      <= 1'b0;
      frame_ready <= 1'b0;
    end else begin
      frame_ready <= 1'b0;
      if (start) begin
        active <= 1'b1;
        idx    <= '0;
        half_q <= half_in;
      end else if (active) begin
        if (idx == IDXW'(WORDS - 1)) begin
          active      <= 1'b0;
          frame_ready <= half_q;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/pkt_addr_node.sv
module pkt_addr_node #(
  parameter logic [31:0] NODE_ID    = 32'h5A17_C0DE,
  parameter logic [15:0] NODE_TYPE  = 16'h0001,
  parameter int unsigned WORDS      = 32,
  parameter int unsigned WORD_W     = 16,
  parameter int unsigned BAD_W      = 16,
  parameter int unsigned WIN_CYCLES = 5_000_000,
  localparam int unsigned IDXW       = $clog2(WORDS),
  localparam int unsigned AW         = IDXW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  input  logic              in_eop,
  input  logic              in_synced,
  output logic              fb_we,
  output logic [AW-1:0]     fb_addr,
  output logic [WORD_W-1:0] fb_data,
  output logic              frame_ready,
  output logic              reply_req,
  output logic [31:0]       reply_id,
  output logic [15:0]       reply_type,
  output logic [BAD_W-1:0]  bad_count
);

  localparam int unsigned HALF_BYTES = WORDS * WORD_W / 8;
  localparam int unsigned LEN_W      = $clog2(HALF_BYTES + 2);

  logic [LEN_W-1:0] pkt_len;
  logic [7:0]       byte0;
  logic [31:0]      addr_word;
  logic             win_open;
  logic             copy_start, copy_half, copy_active, copy_hq;
  logic [IDXW-1:0]  copy_idx;

  // Delimiter that forms a packet: only once the decoder is in sync.
  wire eop_evt = in_valid & in_eop & in_synced;

  pan_rxbuf #(
    .HALF_BYTES(HALF_BYTES), .WORD_W(WORD_W), .LEN_W(LEN_W), .IDXW(IDXW)
  ) u_rx (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_eop(in_eop),
    .in_byte(in_byte), .rd_idx(copy_idx), .pkt_len(pkt_len),
    .byte0(byte0), .addr_word(addr_word), .rd_word(fb_data)
  );

  pan_window #(.WIN_CYCLES(WIN_CYCLES)) u_win (
    .clk(clk), .rst_n(rst_n), .win_open(win_open)
  );

  pan_ctrl #(
    .NODE_ID(NODE_ID), .HALF_BYTES(HALF_BYTES), .LEN_W(LEN_W), .BAD_W(BAD_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .eop_evt(eop_evt), .pkt_len(pkt_len),
    .byte0(byte0), .addr_word(addr_word), .win_open(win_open),
    .reply_req(reply_req), .bad_count(bad_count),
    .copy_start(copy_start), .copy_half(copy_half)
  );

  pan_copy #(.WORDS(WORDS), .IDXW(IDXW)) u_copy (
    .clk(clk), .rst_n(rst_n), .start(copy_start), .half_in(copy_half),
    .active(copy_active), .idx(copy_idx), .half_q(copy_hq),
    .frame_ready(frame_ready)
  );

  assign fb_we      = copy_active;
  assign fb_addr    = {copy_hq, copy_idx};
  assign reply_id   = NODE_ID;
  assign reply_type = NODE_TYPE;

endmodule

// File: rtl/pan_chk.sv
module pan_chk #(
  parameter int unsigned WORDS      = 32,
  parameter int unsigned AW         = 6,
  parameter int unsigned BAD_W      = 16,
  parameter int unsigned WIN_CYCLES = 5_000_000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_eop,
  input logic             in_synced,
  input logic             fb_we,
  input logic [AW-1:0]    fb_addr,
  input logic             frame_ready,
  input logic             reply_req,
  input logic [BAD_W-1:0] bad_count
);
  localparam int unsigned SW = $clog2(WIN_CYCLES + 3);

  logic [SW-1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != SW'(WIN_CYCLES + 2)) since_rst <= since_rst + 1'b1;
  end

  // R7
  frame_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ready |-> ($past(fb_we) && $past(fb_addr) == AW'(2 * WORDS - 1)));

  // R6
  write_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_we && fb_addr[AW-2:0] != '0) |-> ($past(fb_we) && fb_addr == AW'($past(fb_addr) + 1'b1)));

  // R6
  write_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_we && fb_addr[AW-2:0] != (AW-1)'(WORDS - 1)) |=> fb_we);

  // R2
  reply_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reply_req |=> !reply_req);

  // R3
  reply_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reply_req |-> since_rst <= SW'(WIN_CYCLES));

  // R8
  bad_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_count != $past(bad_count)) |->
      (bad_count == $past(bad_count) + 1'b1 && $past(in_valid && in_eop && in_synced)));

  // R10
  unsynced_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && in_eop && !in_synced) |-> (!reply_req && $stable(bad_count)));

  // R11
  bad_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bad_count) == '1) |-> (bad_count == '1));

endmodule

bind pkt_addr_node pan_chk #(
  .WORDS(WORDS), .AW(AW), .BAD_W(BAD_W), .WIN_CYCLES(WIN_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_eop(in_eop),
  .in_synced(in_synced), .fb_we(fb_we), .fb_addr(fb_addr),
  .frame_ready(frame_ready), .reply_req(reply_req), .bad_count(bad_count)
);

// File: tb/sim_pkt_addr_node.sv
`timescale 1ns/1ps
module sim_pkt_addr_node;
  localparam int          WORDS = 32;
  localparam int          WIN   = 1000;
  localparam int          BADW  = 4;
  localparam logic [31:0] MYID  = 32'hA1B2_C3D4;
  localparam logic [15:0] MYTYP = 16'h0301;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        in_valid = 1'b0, in_eop = 1'b0, in_synced = 1'b1;
  logic [7:0]  in_byte = 8'h00;
  logic        fb_we, frame_ready, reply_req;
  logic [5:0]  fb_addr;
  logic [15:0] fb_data, reply_type;
  logic [31:0] reply_id;
  logic [BADW-1:0] bad_count;

  pkt_addr_node #(
    .NODE_ID(MYID), .NODE_TYPE(MYTYP), .WORDS(WORDS), .WORD_W(16),
    .BAD_W(BADW), .WIN_CYCLES(WIN)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_eop(in_eop), .in_synced(in_synced), .fb_we(fb_we), .fb_addr(fb_addr),
    .fb_data(fb_data), .frame_ready(frame_ready), .reply_req(reply_req),
    .reply_id(reply_id), .reply_type(reply_type), .bad_count(bad_count)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0, rst_cyc = 0;
  bit done = 0;
  int m_st = 0, m_bad = 0;
  logic [63:0] exp_q[$];
  string       req_q[$];
  logic [7:0]  pk[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] item(input int c, input int kind, input int addr, input int data);
    return {32'(c), 6'd0, 2'(kind), 8'(addr), 16'(data)};
  endfunction

  task automatic observe(input logic [63:0] o, input bit is_reply);
    logic [63:0] e;
    string r;
    if (exp_q.size() == 0) begin
      chk(0, "R8", "unexpected output item", o, 64'd0);
    end else begin
      e = exp_q.pop_front();
      r = req_q.pop_front();
      chk(o == e, r, "output item {cycle,kind,addr,data}", o, e);
      if (is_reply) begin
        chk(reply_id == MYID, "R2", "reply_id", 64'(reply_id), 64'(MYID));
        chk(reply_type == MYTYP, "R2", "reply_type", 64'(reply_type), 64'(MYTYP));
      end
    end
  endtask

  // Monitor: pops the scoreboard as results appear.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (reply_req)   observe(item(cyc, 2, 0, 0), 1'b1);
      if (fb_we)       observe(item(cyc, 0, int'(fb_addr), int'(fb_data)), 1'b0);
      if (frame_ready) observe(item(cyc, 1, 0, 0), 1'b0);
    end
  end

  function automatic void push(input logic [63:0] it, input string req);
    exp_q.push_back(it);
    req_q.push_back(req);
  endfunction

  function automatic void bad_inc();
    if (m_bad < (1 << BADW) - 1) m_bad++;
    m_st = 0;
  endfunction

  // Driver: sends pk, predicts results from the requirements.
  task automatic send_pkt(input bit synced, input string req);
    int n, e, base;
    n = pk.size();
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_eop = 1'b0; in_byte = pk[i];
    end
    @(negedge clk);
    in_valid = 1'b1; in_eop = 1'b1; in_synced = synced; in_byte = 8'h00;
    e = cyc + 1;
    if (synced) begin
      if (n == 1 && pk[0] == 8'h00) begin
        if (e - rst_cyc < WIN - 5) push(item(e, 2, 0, 0), req);
      end else if (n == 1) begin
        m_st = 0;
      end else if (n == 4) begin
        m_st = ({pk[3], pk[2], pk[1], pk[0]} == MYID) ? 1 : 0;
      end else if (n == 2 * WORDS) begin
        if (m_st == 0) bad_inc();
        else begin
          base = (m_st == 2) ? WORDS : 0;
          for (int k = 0; k < WORDS; k++)
            push(item(e + k, 0, base + k, int'({pk[2*k+1], pk[2*k]})), req);
          if (m_st == 2) push(item(e + WORDS, 1, 0, 0), req);
          m_st = (m_st == 1) ? 2 : 0;
        end
      end else begin
        bad_inc();
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_eop = 1'b0; in_synced = 1'b1;
    repeat (36) @(negedge clk);
    chk(bad_count == BADW'(m_bad), req, "bad_count", 64'(bad_count), 64'(m_bad));
  endtask

  task automatic mk_fill(input int n, input int seed);
    pk.delete();
    for (int i = 0; i < n; i++) pk.push_back(8'(seed + i * 7));
  endtask

  task automatic mk_addr(input logic [31:0] a);
    pk.delete();
    for (int i = 0; i < 4; i++) pk.push_back(a[8*i +: 8]);
  endtask

  task automatic mk_one(input logic [7:0] b);
    pk.delete();
    pk.push_back(b);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    rst_cyc = cyc;
    @(negedge clk);
    // R1 reset state
    chk(bad_count == '0, "R1", "bad_count after reset", 64'(bad_count), 64'd0);
    chk(!fb_we && !frame_ready && !reply_req, "R1", "idle outputs after reset",
        64'({fb_we, frame_ready, reply_req}), 64'd0);
    mk_fill(64, 5);      send_pkt(1'b1, "R1");   // half while ignoring
    mk_addr(MYID);       send_pkt(1'b1, "R5");
    mk_one(8'h00);       send_pkt(1'b1, "R2");   // discovery keeps state
    mk_fill(64, 3);      send_pkt(1'b1, "R6");
    mk_fill(64, 90);     send_pkt(1'b1, "R7");
    mk_fill(64, 11);     send_pkt(1'b1, "R7");   // back to ignoring
    mk_addr(MYID ^ 32'h0000_0100); send_pkt(1'b1, "R5");
    mk_fill(64, 17);     send_pkt(1'b1, "R5");
    mk_addr(MYID);       send_pkt(1'b1, "R4");
    mk_one(8'h05);       send_pkt(1'b1, "R4");
    mk_fill(64, 23);     send_pkt(1'b1, "R4");
    mk_addr(MYID);       send_pkt(1'b1, "R8");
    mk_fill(2, 1);       send_pkt(1'b1, "R8");
    mk_fill(64, 29);     send_pkt(1'b1, "R8");
    mk_addr(MYID);       send_pkt(1'b1, "R10");
    mk_fill(3, 9);       send_pkt(1'b0, "R10");  // unsynced delimiter
    mk_fill(64, 40);     send_pkt(1'b1, "R10");
    mk_fill(70, 2);      send_pkt(1'b1, "R9");   // oversize in second-half state
    while (cyc - rst_cyc < WIN + 50) @(negedge clk);
    mk_one(8'h00);       send_pkt(1'b1, "R3");   // late discovery
    for (int i = 0; i < 10; i++) begin
      pk.delete();       send_pkt(1'b1, "R11");  // empty packets to saturation
    end
    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R6", "pending expected items", 64'(exp_q.size()), 64'd0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule